// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirty-two interrupt sources and drives one active-low interrupt request line to a processor. Each source has a control register. The register selects how the source is sensed and gives the source a three-bit priority. A source can be sensed as a low level, a high level, a falling edge or a rising edge. Every source input first passes through a synchronizer. Edge-sensed sources then latch a pending flag. A priority resolver picks one winner among the enabled pending sources.

Software works through a simple register bus. An interrupt is taken by reading the acknowledge-vector register. That read returns the winner's index times four, which suits a jump-table offset. The read also pushes the winner's priority onto an in-service record. While a level is in service, only a strictly more urgent source can pull the request line low again. A write of any value to the end-of-service register pops the most recent level. A second register reports the current winner without acknowledging it.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every source is disabled, every control register reads 0 (low-level sensing, priority 0), the enable register reads 0 and `irq_n` is high.
- R2: The control register for source i is at byte address 4*i. Bits 7:6 select the sensing: 00 low level, 01 high level, 10 falling edge, 11 rising edge. Bits 2:0 hold the priority. Bits 5:3 and 31:8 read as 0 and ignore writes.
- R3: Writing ones to address 0x80 enables the matching sources, and reading 0x80 returns the enable vector. Writing ones to 0x84 disables the matching sources. A disabled source never pulls `irq_n` low.
- R4: A level-sensed source is pending exactly while its synchronized input sits at the selected level. An edge-sensed source latches a pending flag on the selected edge, even while it is disabled. The flag is cleared when that source is acknowledged.
- R5: Priority value 0 is the most urgent. Among enabled pending sources of equal priority, the lowest index wins.
- R6: A read of 0x88 returns the winner index times four. From the following cycle `irq_n` is high, unless a more urgent source is pending. A read of 0x88 while no request is raised returns 0 and changes nothing.
- R7: A read of 0x8C returns the index of the source that is raising the request, or 0 when there is none. The read has no side effects.
- R8: After an acknowledge, a source raises `irq_n` only if its priority value is strictly lower than the most recent in-service level.
- R9: Any write to 0x90 removes the most recent in-service level, which restores the previous threshold. With no level in service the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt source inputs |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the read strobe is high |
| irq_n | output | 1 | Interrupt request to the processor, active low |

## Verification
Some rules are checked by assertions on every cycle:
- the resolver only names a requesting source below the in-service threshold;
- each acknowledge pushes exactly one level, and that level becomes the new threshold;
- each end-of-service on a non-empty record pops exactly one level;
- disabling all sources silences the request line.

The remaining rules need the bench's scenarios:
- the tie-break between equal priorities;
- edge flags latched while disabled and cleared on acknowledge;
- the side-effect-free source-number read;
- equal-priority sources held off during nesting.

Long randomized runs compare every acknowledge vector and every level of `irq_n` against a model in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int PRIO_W  = 3;
    localparam int NUM_LVL = 1 << PRIO_W;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e             trig;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam logic [ADDR_W-1:0] A_EN_SET = 8'h80;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 8'h84;
    localparam logic [ADDR_W-1:0] A_ACK    = 8'h88;
    localparam logic [ADDR_W-1:0] A_SRCNUM = 8'h8C;
    localparam logic [ADDR_W-1:0] A_EOS    = 8'h90;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [STAGES-1:0][N-1:0] chain_d, chain_q;
    logic [N-1:0]             prev_d, prev_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int N  = 32,
    parameter int PW = 3,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic [PW:0]          thr_i,
    output logic                 valid_o,
    output logic [IW-1:0]        idx_o,
    output logic [PW-1:0]        prio_o
);
    always_comb begin
        logic [PW:0] best;
        best    = thr_i;
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        // strict compare keeps the lowest index on ties
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && ({1'b0, prio_i[i]} < best)) begin
                best    = {1'b0, prio_i[i]};
                valid_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i];
            end
        end
    end

    assert_win_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (req_i[idx_o] && ({1'b0, prio_o} < thr_i) && (prio_o == prio_i[idx_o])));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        src_i,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);
    localparam int IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0] cfg;
        logic [NUM_SRC-1:0]     en;
        logic [NUM_SRC-1:0]     epend;
        logic [NUM_LVL-1:0]     isr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0]             lvl, rise, fall, req;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
    logic [PRIO_W:0]                thr;
    logic                           win_valid;
    logic [IDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio;
    logic                           wr_fire, rd_fire, ack_fire, eos_fire, cfg_hit;
    logic [4:0]                     cfg_sel;

    irqc_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(src_i[NUM_SRC-1:0]),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    // pending view per source and priority fan-out
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            prio_vec[i] = st_q.cfg[i].prio;
            case (st_q.cfg[i].trig)
                TRIG_LOW:  req[i] = st_q.en[i] & ~lvl[i];
                TRIG_HIGH: req[i] = st_q.en[i] & lvl[i];
                default:   req[i] = st_q.en[i] & st_q.epend[i];
            endcase
        end
    end

    // threshold = most urgent level currently in service, NUM_LVL if none
    always_comb begin
        thr = (PRIO_W+1)'(NUM_LVL);
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (st_q.isr[l]) thr = (PRIO_W+1)'(l);
        end
    end

    irqc_pick #(.N(NUM_SRC), .PW(PRIO_W)) pick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .prio_i (prio_vec),
        .thr_i  (thr),
        .valid_o(win_valid),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    assign irq_n    = ~win_valid;
    assign wr_fire  = bus_en & bus_wr;
    assign rd_fire  = bus_en & ~bus_wr;
    assign ack_fire = rd_fire && (bus_addr == A_ACK) && win_valid;
    assign eos_fire = wr_fire && (bus_addr == A_EOS);
    assign cfg_sel  = bus_addr[6:2];
    assign cfg_hit  = !bus_addr[ADDR_W-1] && (int'(cfg_sel) < NUM_SRC);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            bus_rdata = DATA_W'({st_q.cfg[cfg_sel].trig, 3'b000, st_q.cfg[cfg_sel].prio});
        end else begin
            case (bus_addr)
                A_EN_SET: bus_rdata = DATA_W'(st_q.en);
                A_ACK:    bus_rdata = win_valid ? DATA_W'({win_idx, 2'b00}) : '0;
                A_SRCNUM: bus_rdata = win_valid ? DATA_W'(win_idx) : '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (ack_fire) begin
            st_d.isr[win_prio]  = 1'b1;
            st_d.epend[win_idx] = 1'b0;
        end
        // a new edge wins over a same-cycle acknowledge clear
        for (int i = 0; i < NUM_SRC; i++) begin
            case (st_q.cfg[i].trig)
                TRIG_RISE: if (rise[i]) st_d.epend[i] = 1'b1;
                TRIG_FALL: if (fall[i]) st_d.epend[i] = 1'b1;
                default: ;
            endcase
        end
        if (wr_fire) begin
            if (cfg_hit) begin
                st_d.cfg[cfg_sel].trig = trig_e'(bus_wdata[7:6]);
                st_d.cfg[cfg_sel].prio = bus_wdata[PRIO_W-1:0];
            end else begin
                case (bus_addr)
                    A_EN_SET: st_d.en  = st_q.en | bus_wdata[NUM_SRC-1:0];
                    A_EN_CLR: st_d.en  = st_q.en & ~bus_wdata[NUM_SRC-1:0];
                    A_EOS:    st_d.isr = st_q.isr & (st_q.isr - 1'b1);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ack_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> ($countones(st_q.isr) == $past($countones(st_q.isr)) + 1));

    assert_nest_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (thr == {1'b0, $past(win_prio)}));

    assert_eos_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_fire && (st_q.isr != '0)) |=> ($countones(st_q.isr) == $past($countones(st_q.isr)) - 1));

    assert_mask_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && (bus_addr == A_EN_CLR) && (&bus_wdata[NUM_SRC-1:0])) |=> ((st_q.en == '0) && irq_n));
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    import irqc_pkg::*;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '1;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    always #2 clk = ~clk;

    irq_vec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [1:0]   m_trig [N];
    logic [2:0]   m_prio [N];
    logic [N-1:0] m_en, m_ep;
    logic [7:0]   m_isr;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic void m_win(output bit v, output int idx);
        int thr;
        bit pend;
        thr = 8;
        for (int l = 7; l >= 0; l--) if (m_isr[l]) thr = l;
        v = 0; idx = 0;
        for (int i = 0; i < N; i++) begin
            case (m_trig[i])
                2'b00:   pend = !src[i];
                2'b01:   pend = src[i];
                default: pend = m_ep[i];
            endcase
            if (m_en[i] && pend && int'(m_prio[i]) < thr) begin
                thr = int'(m_prio[i]); v = 1; idx = i;
            end
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic cfg(input int i, input logic [31:0] d);
        wr(8'(i * 4), d);
        m_trig[i] = d[7:6];
        m_prio[i] = d[2:0];
    endtask

    task automatic en_set(input logic [31:0] m);
        wr(A_EN_SET, m);
        m_en |= m;
    endtask

    task automatic en_clr(input logic [31:0] m);
        wr(A_EN_CLR, m);
        m_en &= ~m;
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk);
        if (m_trig[i] == 2'b11 && !src[i] && v) m_ep[i] = 1;
        if (m_trig[i] == 2'b10 && src[i] && !v) m_ep[i] = 1;
        src[i] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_ack(input string req);
        bit v; int idx; logic [31:0] d;
        m_win(v, idx);
        rd(A_ACK, d);
        check(req, d, v ? 32'(idx * 4) : 32'd0);
        if (v) begin
            m_isr[m_prio[idx]] = 1;
            m_ep[idx] = 0;
        end
    endtask

    task automatic do_eos();
        wr(A_EOS, $urandom);
        m_isr = m_isr & (m_isr - 8'd1);
    endtask

    task automatic check_irq(input string req);
        bit v; int idx;
        m_win(v, idx);
        #1 check(req, {31'b0, irq_n}, {31'b0, !v});
    endtask

    task automatic check_num(input string req);
        bit v; int idx; logic [31:0] d;
        m_win(v, idx);
        rd(A_SRCNUM, d);
        check(req, d, v ? 32'(idx) : 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 0; src = '1; bus_en = 0; bus_wr = 0;
        for (int i = 0; i < N; i++) begin m_trig[i] = 0; m_prio[i] = 0; end
        m_en = '0; m_ep = '0; m_isr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed_v;
        seed_v = $urandom(32'd20517);
        do_reset();

        // R1 reset state
        check_irq("R1 irq idle");
        rd(A_EN_SET, d);  check("R1 enables", d, 32'h0);
        rd(8'h14, d);     check("R1 ctrl5", d, 32'h0);
        do_ack("R6 ack without request");

        // R2 field layout and reserved bits
        cfg(3, 32'hFFFF_FFC5);
        rd(8'h0C, d);     check("R2 ctrl readback", d, 32'hC5);
        cfg(3, 32'h0);

        // R3 masking
        cfg(7, 32'h43);
        check_irq("R3 masked source silent");
        en_set(32'h80);
        check_irq("R3 enabled source raises");
        rd(A_EN_SET, d);  check("R3 enable readback", d, 32'h80);
        en_clr(32'hFFFF_FFFF);
        check_irq("R3 all masked");
        rd(A_EN_SET, d);  check("R3 enable cleared", d, 32'h0);

        // R5 tie break and priority
        cfg(4, 32'h42); cfg(9, 32'h42);
        en_set(32'h290);
        check_num("R5 lowest index on tie");

        // R7 no side effect, R6 acknowledge
        check_num("R7 repeat read");
        check_irq("R7 irq still raised");
        rd(A_ACK, d); check("R6 vector", d, 32'd16);
        m_isr[2] = 1;
        check_irq("R6 irq released");

        // R8 nesting
        check_irq("R8 equal priority held off");
        cfg(20, 32'hC0); en_set(32'h0010_0000);
        set_src(20, 0); set_src(20, 1);
        check_irq("R8 more urgent raises");
        check_num("R8 winner 20");
        do_ack("R6 vector 80");
        check_irq("R8 held at level 0");

        // R9 end of service
        do_eos();
        check_irq("R9 back to level 2");
        check_num("R4 edge cleared by ack");
        do_eos();
        check_irq("R9 stack empty");
        check_num("R9 winner 4 again");
        do_eos();
        check_irq("R9 empty pop no effect");

        // R4 edge latched while masked
        en_clr(32'h0010_0290);
        cfg(25, 32'h81);
        set_src(25, 0);
        check_irq("R4 masked edge silent");
        set_src(25, 1);
        en_set(32'h0200_0000);
        check_irq("R4 latched edge raises");
        check_num("R4 winner 25");
        do_ack("R6 vector 100");
        do_eos();
        check_irq("R4 edge flag cleared");

        // R4 low level
        cfg(30, 32'h04); en_set(32'h4000_0000);
        check_irq("R4 low level inactive");
        set_src(30, 0);
        check_num("R4 low level pending");
        set_src(30, 1);
        check_irq("R4 level not latched");

        // randomized phase
        do_reset();
        for (int it = 0; it < 600; it++) begin
            int act;
            act = $urandom_range(0, 9);
            case (act)
                0: cfg($urandom_range(0, N - 1), $urandom);
                1: en_set($urandom & $urandom);
                2: en_clr($urandom & $urandom & $urandom);
                3, 4, 5: begin
                    int b;
                    b = $urandom_range(0, N - 1);
                    set_src(b, ~src[b]);
                end
                6, 7: do_ack("R6 random ack");
                8: do_eos();
                default: check_num("R7 random source number");
            endcase
            check_irq("R8 random irq level");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule